// File: doc/BRIEF.md
# Multi-Granule Allocation Tag Checker

This block decides whether a memory access may proceed by comparing a 4-bit pointer tag with the allocation tags stored for every 16-byte granule the access touches. Tag storage is external and packed two tags per byte: the granule with address bit 4 clear sits in the low nibble of its byte, the granule with bit 4 set sits in the high nibble. The block reads that storage through a simple read port whose data returns one cycle after the request.

A start strobe launches a walk over the granules of the access. The walk goes either upward from the start address (forward mode) or downward from it (reverse mode, used when a copy runs from high addresses to low). The walk stops at the first granule whose stored tag differs from the pointer tag. A done strobe then carries the verdict, the number of granules that matched, and the address to report as the fault. The verdict stays on the outputs until the next accepted start.

Top module: `tag_granule_checker`

## Requirements
- R1: After reset, busy, done, pass, match_cnt, fault_addr and tm_rd_en are all zero.
- R2: In forward mode the access covers bytes addr to addr+size_m1. The granule count is floor((addr+size_m1)/16) - floor(addr/16) + 1. When every covered granule matches, pass is 1 and match_cnt equals that count.
- R3: Granule g = addr>>4 is stored in tag byte g>>1, so the first read address is addr>>5. The nibble is bits 7:4 when g is odd (address bit 4 set) and bits 3:0 when g is even.
- R4: Forward mode visits granules g0, g0+1, g0+2 and so on. A walk that starts at an odd granule therefore reads the high nibble first and then moves to the low nibble of the next byte.
- R5: Reverse mode (rev=1) treats the access as bytes addr-size_m1 to addr. Its count is floor(addr/16) - floor((addr-size_m1)/16) + 1. It visits g0, g0-1 and so on downward, reading the high nibble first when address bit 4 is set.
- R6: A granule matches when its stored nibble equals ptr_tag. The walk stops at the first mismatch. pass is then 0 and match_cnt is the number of granules that matched before it.
- R7: On a failure with match_cnt = 0, fault_addr is the start address addr. With match_cnt = n > 0, fault_addr is 16*(g0+n) in forward mode and 16*(g0-n) in reverse mode, the base of the failing granule.
- R8: Counting the clock edge that samples start as edge 0, done is high for exactly one cycle after edge T+1 on a pass of T granules, or after edge k+2 when granule index k fails. busy is low in the done cycle, and the results hold until the next accepted start.
- R9: A start strobe that arrives while busy is 1 is ignored, and the running walk finishes with its own result.
- R10: Each granule needs one read. tm_rd_en is only high while busy. A walk issues exactly T reads on a pass, and min(k+2, T) reads when granule index k fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a walk (sampled when idle) |
| rev | input | 1 | 1 = reverse (descending) walk |
| addr | input | ADDR_W | Start address of the access |
| size_m1 | input | SIZE_W | Access length in bytes minus one |
| ptr_tag | input | 4 | Pointer tag to compare |
| tm_rd_en | output | 1 | Tag memory read request |
| tm_rd_addr | output | ADDR_W-5 | Tag byte index |
| tm_rd_data | input | 8 | Tag byte, valid the cycle after the request |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle strobe: result valid |
| pass | output | 1 | All covered granules matched |
| match_cnt | output | SIZE_W-3 | Granules matched |
| fault_addr | output | ADDR_W | Address reported for the fault |

## Verification
Timing is counted from the edge that samples start. The first tag read request is visible in the cycle after that edge. done rises after edge T+1 on a pass, or after edge k+2 when granule k fails. The bench pulses start at a falling edge and then counts rising edges. It samples every output at the next falling edge, so it checks the done latency against the exact edge count from R8, counts read requests against R10 over the same window, and captures the first read address for R3. The verdict, count and fault address are read in the done cycle and compared with a bench model that walks its own copy of the tag bytes.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
   localparam int GRAN_LSB = 4;
   localparam int TAG_W    = 4;
   localparam int BYTE_W   = 2 * TAG_W;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_st_e;
endpackage

// File: rtl/tgc_span.sv
module tgc_span
   import tgc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 8,
   parameter int CNT_W  = 5,
   parameter bit REV_EN = 1'b1
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [SIZE_W-1:0]          size_m1,
   input  logic                       rev,
   output logic [ADDR_W-GRAN_LSB-1:0] g_first,
   output logic [CNT_W-1:0]           g_total
);
   localparam int GI_W = ADDR_W - GRAN_LSB;

   logic [ADDR_W-1:0] size_ext;
   logic [ADDR_W-1:0] top_byte;
   logic [GI_W-1:0]   span_up;

   assign size_ext = ADDR_W'(size_m1);
   assign g_first  = addr[ADDR_W-1:GRAN_LSB];
   assign top_byte = addr + size_ext;
   assign span_up  = top_byte[ADDR_W-1:GRAN_LSB] - g_first;

   generate
      if (REV_EN) begin : g_both
         logic [ADDR_W-1:0] bot_byte;
         logic [GI_W-1:0]   span_dn;
         assign bot_byte = addr - size_ext;
         assign span_dn  = g_first - bot_byte[ADDR_W-1:GRAN_LSB];
         assign g_total  = (rev ? CNT_W'(span_dn) : CNT_W'(span_up)) + CNT_W'(1);
      end else begin : g_fwd_only
         logic unused_rev;
         assign unused_rev = rev;
         assign g_total    = CNT_W'(span_up) + CNT_W'(1);
      end
   endgenerate
endmodule

// File: rtl/tgc_nib_match.sv
module tgc_nib_match
   import tgc_pkg::*;
(
   input  logic [BYTE_W-1:0] tag_byte,
   input  logic [TAG_W-1:0]  ref_tag,
   input  logic              odd,
   output logic              hit
);
   logic [BYTE_W-1:0] diff;

   assign diff = tag_byte ^ {2{ref_tag}};
   assign hit  = odd ? (diff[BYTE_W-1:TAG_W] == '0) : (diff[TAG_W-1:0] == '0);
endmodule

// File: rtl/tgc_fault.sv
module tgc_fault
   import tgc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 5
) (
   input  logic [ADDR_W-1:0]          start_addr,
   input  logic [ADDR_W-GRAN_LSB-1:0] g_first,
   input  logic [CNT_W-1:0]           n_ok,
   input  logic                       rev,
   output logic [ADDR_W-1:0]          fault
);
   localparam int GI_W = ADDR_W - GRAN_LSB;

   logic [GI_W-1:0] n_ext;
   logic [GI_W-1:0] g_bad;

   assign n_ext = GI_W'(n_ok);
   assign g_bad = rev ? (g_first - n_ext) : (g_first + n_ext);
   assign fault = (n_ok == '0) ? start_addr : {g_bad, {GRAN_LSB{1'b0}}};
endmodule

// File: rtl/tag_granule_checker.sv
module tag_granule_checker
   import tgc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 8,
   parameter bit REV_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       rev,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [SIZE_W-1:0]          size_m1,
   input  logic [TAG_W-1:0]           ptr_tag,
   output logic                       tm_rd_en,
   output logic [ADDR_W-GRAN_LSB-2:0] tm_rd_addr,
   input  logic [BYTE_W-1:0]          tm_rd_data,
   output logic                       busy,
   output logic                       done,
   output logic                       pass,
   output logic [SIZE_W-4:0]          match_cnt,
   output logic [ADDR_W-1:0]          fault_addr
);
   localparam int GI_W  = ADDR_W - GRAN_LSB;
   localparam int CNT_W = SIZE_W - 3;

   generate
      if (SIZE_W < 5) begin : g_bad_size
         $error("tag_granule_checker: SIZE_W must be at least 5");
      end
      if (ADDR_W < SIZE_W + 6) begin : g_bad_addr
         $error("tag_granule_checker: ADDR_W too small for SIZE_W");
      end
   endgenerate

   walk_st_e          st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [GI_W-1:0]   g0_q;
   logic [GI_W-1:0]   ig_q;
   logic [CNT_W-1:0]  tot_q;
   logic [CNT_W-1:0]  left_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [TAG_W-1:0]  tag_q;
   logic              rev_q;
   logic              chk_v_q;
   logic              chk_odd_q;
   logic              done_q;
   logic              pass_q;
   logic [ADDR_W-1:0] fault_q;

   logic [GI_W-1:0]   g_first;
   logic [CNT_W-1:0]  g_total;
   logic              hit;
   logic [ADDR_W-1:0] fault_w;
   logic              rd_en;
   logic              rev_eff;

   assign rev_eff = REV_EN ? rev : 1'b0;

   tgc_span #(
      .ADDR_W (ADDR_W),
      .SIZE_W (SIZE_W),
      .CNT_W  (CNT_W),
      .REV_EN (REV_EN)
   ) u_span (
      .addr    (addr),
      .size_m1 (size_m1),
      .rev     (rev_eff),
      .g_first (g_first),
      .g_total (g_total)
   );

   tgc_nib_match u_match (
      .tag_byte (tm_rd_data),
      .ref_tag  (tag_q),
      .odd      (chk_odd_q),
      .hit      (hit)
   );

   tgc_fault #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_fault (
      .start_addr (addr_q),
      .g_first    (g0_q),
      .n_ok       (cnt_q),
      .rev        (rev_q),
      .fault      (fault_w)
   );

   assign rd_en = (st_q == WALK_RUN) && (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= WALK_IDLE;
         addr_q    <= '0;
         g0_q      <= '0;
         ig_q      <= '0;
         tot_q     <= '0;
         left_q    <= '0;
         cnt_q     <= '0;
         tag_q     <= '0;
         rev_q     <= 1'b0;
         chk_v_q   <= 1'b0;
         chk_odd_q <= 1'b0;
         done_q    <= 1'b0;
         pass_q    <= 1'b0;
         fault_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            WALK_IDLE: begin
               if (start) begin
                  st_q    <= WALK_RUN;
                  addr_q  <= addr;
                  rev_q   <= rev_eff;
                  tag_q   <= ptr_tag;
                  g0_q    <= g_first;
                  ig_q    <= g_first;
                  tot_q   <= g_total;
                  left_q  <= g_total;
                  cnt_q   <= '0;
                  chk_v_q <= 1'b0;
                  pass_q  <= 1'b0;
                  fault_q <= '0;
               end
            end
            WALK_RUN: begin
               chk_v_q <= rd_en;
               if (rd_en) begin
                  ig_q      <= rev_q ? (ig_q - GI_W'(1)) : (ig_q + GI_W'(1));
                  left_q    <= left_q - CNT_W'(1);
                  chk_odd_q <= ig_q[0];
               end
               if (chk_v_q) begin
                  if (hit) begin
                     cnt_q <= cnt_q + CNT_W'(1);
                     if (cnt_q + CNT_W'(1) == tot_q) begin
                        st_q    <= WALK_IDLE;
                        done_q  <= 1'b1;
                        pass_q  <= 1'b1;
                        fault_q <= addr_q;
                        chk_v_q <= 1'b0;
                     end
                  end else begin
                     st_q    <= WALK_IDLE;
                     done_q  <= 1'b1;
                     pass_q  <= 1'b0;
                     fault_q <= fault_w;
                     chk_v_q <= 1'b0;
                  end
               end
            end
            default: st_q <= WALK_IDLE;
         endcase
      end
   end

   assign tm_rd_en   = rd_en;
   assign tm_rd_addr = ig_q[GI_W-1:1];
   assign busy       = (st_q == WALK_RUN);
   assign done       = done_q;
   assign pass       = pass_q;
   assign match_cnt  = cnt_q;
   assign fault_addr = fault_q;
endmodule

// File: rtl/tgc_checker.sv
module tgc_checker #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              pass,
   input logic              tm_rd_en,
   input logic [CNT_W-1:0]  match_cnt,
   input logic [ADDR_W-1:0] fault_addr,
   input logic [ADDR_W-1:0] addr_q,
   input logic [CNT_W-1:0]  tot_q
);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   rd_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tm_rd_en |-> busy);

   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (addr_q == $past(addr_q)));

   // R2
   pass_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pass) |-> (match_cnt == tot_q));

   // R6
   fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pass) |-> (match_cnt < tot_q));

   // R7
   first_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !pass && match_cnt == '0) |-> (fault_addr == addr_q));
endmodule

bind tag_granule_checker tgc_checker #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_tgc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .pass       (pass),
   .tm_rd_en   (tm_rd_en),
   .match_cnt  (match_cnt),
   .fault_addr (fault_addr),
   .addr_q     (addr_q),
   .tot_q      (tot_q)
);

// File: tb/tag_granule_checker_bench.sv
module tag_granule_checker_bench;
   localparam int AW = 32;
   localparam int SW = 8;
   localparam int CW = SW - 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rev = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [SW-1:0] size_m1 = '0;
   logic [3:0]    ptr_tag = '0;
   logic          tm_rd_en;
   logic [AW-6:0] tm_rd_addr;
   logic [7:0]    tm_rd_data;
   logic          busy, done, pass;
   logic [CW-1:0] match_cnt;
   logic [AW-1:0] fault_addr;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_total = 0;

   logic [7:0] mem [64];

   always #5 clk = ~clk;

   tag_granule_checker #(.ADDR_W(AW), .SIZE_W(SW), .REV_EN(1'b1)) u_tag_granule_checker (
      .clk(clk), .rst_n(rst_n), .start(start), .rev(rev), .addr(addr),
      .size_m1(size_m1), .ptr_tag(ptr_tag), .tm_rd_en(tm_rd_en),
      .tm_rd_addr(tm_rd_addr), .tm_rd_data(tm_rd_data), .busy(busy),
      .done(done), .pass(pass), .match_cnt(match_cnt), .fault_addr(fault_addr)
   );

   always_ff @(posedge clk) begin
      if (tm_rd_en) tm_rd_data <= mem[tm_rd_addr[5:0]];
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] a, input int sz, input logic [3:0] tg,
                                 input bit rv, output int tot, output int n, output logic [31:0] flt);
      logic [31:0] g0, gb, g;
      logic [7:0]  b;
      logic [3:0]  nib;
      g0 = a >> 4;
      if (!rv) begin gb = (a + 32'(sz)) >> 4; tot = int'(gb - g0) + 1; end
      else     begin gb = (a - 32'(sz)) >> 4; tot = int'(g0 - gb) + 1; end
      n = 0;
      for (int i = 0; i < tot; i++) begin
         g   = rv ? g0 - 32'(i) : g0 + 32'(i);
         b   = mem[g[6:1]];
         nib = g[0] ? b[7:4] : b[3:0];
         if (nib != tg) break;
         n++;
      end
      if (n == tot || n == 0) flt = a;
      else flt = (rv ? (g0 - 32'(n)) : (g0 + 32'(n))) << 4;
   endfunction

   task automatic fill(input logic [3:0] tg);
      for (int i = 0; i < 64; i++) mem[i] = {tg, tg};
   endtask

   task automatic corrupt(input logic [31:0] g);
      mem[g[6:1]] = mem[g[6:1]] ^ (g[0] ? 8'h90 : 8'h09);
   endtask

   // inj=1 pulses a conflicting start while the walk runs (R9)
   task automatic run(input logic [31:0] a, input int sz, input logic [3:0] tg,
                      input bit rv, input bit inj, input string tagname);
      int tot, n, cyc, reads, exp_lat, exp_reads;
      logic [31:0] flt;
      logic [26:0] first_ra;
      bit seen;
      model(a, sz, tg, rv, tot, n, flt);
      @(negedge clk);
      addr = a; size_m1 = SW'(sz); ptr_tag = tg; rev = rv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      addr = '0; size_m1 = '0; ptr_tag = ~tg; rev = ~rv;
      cyc = 1; reads = 0; seen = 0; first_ra = '0;
      while (1) begin
         if (tm_rd_en) begin
            if (reads == 0) first_ra = tm_rd_addr;
            reads++;
         end
         if (done) begin seen = 1; break; end
         if (cyc > 60) break;
         if (inj && cyc == 3) begin
            addr = a ^ 32'h40; size_m1 = 8'd3; ptr_tag = ~tg; start = 1'b1;
         end else start = 1'b0;
         @(posedge clk); cyc++; @(negedge clk);
      end
      start = 1'b0;
      exp_lat   = (n == tot) ? tot + 1 : n + 2;
      exp_reads = (n == tot) ? tot : ((n + 2 < tot) ? n + 2 : tot);
      chk(seen, {tagname, " R8 done seen"}, 64'(seen), 64'd1);
      chk(cyc - 1 == exp_lat, {tagname, " R8 latency"}, 64'(cyc - 1), 64'(exp_lat));
      chk(!busy, {tagname, " R8 idle at done"}, 64'(busy), 64'd0);
      chk(pass == (n == tot), {tagname, " R2 R6 pass"}, 64'(pass), 64'(n == tot));
      chk(int'(match_cnt) == n, {tagname, " R6 match_cnt"}, 64'(match_cnt), 64'(n));
      chk(fault_addr == flt, {tagname, " R7 fault_addr"}, 64'(fault_addr), 64'(flt));
      chk(first_ra == 27'(a >> 5), {tagname, " R3 first read addr"}, 64'(first_ra), 64'(a >> 5));
      chk(reads == exp_reads, {tagname, " R10 read count"}, 64'(reads), 64'(exp_reads));
      @(posedge clk); @(negedge clk);
      chk(!done && pass == (n == tot) && int'(match_cnt) == n, {tagname, " R8 result held"},
          64'(match_cnt), 64'(n));
   endtask

   initial begin
      while (1) begin
         @(posedge clk);
         cyc_total++;
         if (cyc_total > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin
      int seed_dummy;
      logic [31:0] a, g0;
      int sz, tot;
      logic [3:0] tg;
      bit rv;
      seed_dummy = $urandom(32'h5EED_71A6);
      fill(4'h3);
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !pass && match_cnt == '0 && fault_addr == '0 && !tm_rd_en,
          "R1 reset outputs", {busy, done, pass, tm_rd_en}, 64'd0);
      rst_n = 1'b1;

      // R2 single aligned granule pass
      fill(4'h5);
      run(32'h100, 15, 4'h5, 1'b0, 1'b0, "d1");
      // R4 odd start, second granule (low nibble of next byte) bad
      fill(4'hA); corrupt(32'h12);
      run(32'h110, 31, 4'hA, 1'b0, 1'b0, "d2");
      // R4 odd start, only the high nibble of the first byte bad: fails immediately
      fill(4'hA); corrupt(32'h11);
      run(32'h110, 31, 4'hA, 1'b0, 1'b0, "d2b");
      // R7 first granule fails, unaligned start
      fill(4'h7); corrupt(32'h13);
      run(32'h135, 40, 4'h7, 1'b0, 1'b0, "d3");
      // R5 reverse, middle granule bad
      fill(4'hC); corrupt(32'h3E);
      run(32'h3F8, 40, 4'hC, 1'b1, 1'b0, "d4");
      // R5 reverse from even granule, high nibble of lower byte bad
      fill(4'h2); corrupt(32'h3D);
      run(32'h3E4, 20, 4'h2, 1'b1, 1'b0, "d5");
      // R5 reverse full pass
      fill(4'h9);
      run(32'h4F0, 200, 4'h9, 1'b1, 1'b0, "d6");
      // R2 maximum span, 17 granules
      fill(4'h1);
      run(32'h10F, 255, 4'h1, 1'b0, 1'b0, "d7");
      // R9 start while busy is ignored
      fill(4'hE); corrupt(32'h2C);
      run(32'h200, 255, 4'hE, 1'b0, 1'b1, "d8");
      fill(4'h6);
      run(32'h600, 180, 4'h6, 1'b1, 1'b1, "d9");

      for (int t = 0; t < 80; t++) begin
         rv = 1'($urandom_range(0, 1));
         sz = int'($urandom_range(0, 255));
         tg = 4'($urandom_range(0, 15));
         if (rv) a = 32'($urandom_range(300, 2047));
         else    a = 32'($urandom_range(0, 1700));
         fill(tg);
         g0  = a >> 4;
         tot = rv ? int'(g0 - ((a - 32'(sz)) >> 4)) + 1 : int'(((a + 32'(sz)) >> 4) - g0) + 1;
         if ($urandom_range(0, 2) != 0) begin
            int k;
            k = int'($urandom_range(0, tot - 1));
            corrupt(rv ? g0 - 32'(k) : g0 + 32'(k));
         end
         run(a, sz, tg, rv, 1'b0, "rnd");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule